// File: doc/BRIEF.md
# Serial Baud Rate Generator

This block turns the peripheral clock into the timing enables a serial port needs. A power-of-four prescaler (divide by 1, 4, 16 or 64) feeds a programmable divider that divides by N+1. The divider's output is the base tick, which is a single-cycle enable. In asynchronous mode the base tick acts as the oversampling clock, and every 16th or every 8th base tick becomes a bit tick. In clock-synchronous mode a serial clock output toggles on every base tick, so each bit gets one full period of that clock with a 50% duty cycle.

In normal mode the base tick fires every 2·4^n·(N+1) peripheral cycles. In double-speed mode it fires every 4^n·(N+1) cycles, which halves every asynchronous bit period. Synchronous mode always uses the normal base rate.

A change to any configuration input restarts every internal count from zero and returns the serial clock to its idle high level. A one-cycle synchronous clear input does the same. All outputs are enables in the peripheral clock domain. The generator creates no derived clock.

Top module: `serial_baud_gen`

## Requirements
- R1: While reset is active, base_tick and bit_tick are 0 and sclk is 1.
- R2: presc_sel selects the prescaler: 00 gives /1, 01 gives /4, 10 gives /16 and 11 gives /64 (4^n for n = presc_sel). In normal mode the base tick period is 2·4^n·(N+1) cycles.
- R3: The divider divides by divisor+1 for every divisor value from 0 to 255, including both end values.
- R4: In asynchronous normal mode with ratio8=0 (16x), bit_tick fires once every 32·4^n·(N+1) cycles.
- R5: In asynchronous normal mode with ratio8=1 (8x), bit_tick fires once every 16·4^n·(N+1) cycles.
- R6: In asynchronous mode with dbl_speed=1, base_tick fires every 4^n·(N+1) cycles. bit_tick then fires every 16·4^n·(N+1) cycles with ratio8=0 and every 8·4^n·(N+1) cycles with ratio8=1.
- R7: In synchronous mode (sync_mode=1), bit_tick fires every 4·4^n·(N+1) cycles. sclk stays low for one base period and high for one base period. sclk changes only on the cycle after a base tick. dbl_speed has no effect in this mode.
- R8: In asynchronous mode, sclk stays at 1.
- R9: A change to any configuration input, or a one-cycle pulse on sync_clr, restarts the counts. sclk is 1 on the next cycle. The first base_tick after the change appears exactly one base period later, counted in cycles from the cycle of the change. No tick is issued during the clearing cycle.
- R10: bit_tick is a single-cycle pulse and is only ever high together with base_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_clr | input | 1 | Synchronous clear of all counts |
| presc_sel | input | 2 | Prescaler select n, giving a divide ratio of 4^n |
| divisor | input | 8 | Divisor N; the divider divides by N+1 |
| dbl_speed | input | 1 | Double-speed mode (asynchronous mode only) |
| ratio8 | input | 1 | 1: 8 base ticks per bit, 0: 16 base ticks per bit |
| sync_mode | input | 1 | 1: clock-synchronous mode, 0: asynchronous mode |
| base_tick | output | 1 | Base (oversampling) tick enable |
| bit_tick | output | 1 | Once-per-bit tick enable |
| sclk | output | 1 | Serial clock in synchronous mode, idle high |

## Verification
All four prescaler selects are run with small divisors, so an error in the 4^n scaling changes the measured period by a factor of four. Divisors of 0 and 255 check both ends of the N+1 divider. The 8x/16x ratio is swept with double speed both off and on, and each mode must give its own bit period. Two more checks separate the two timebases: synchronous mode must ignore double speed, and the serial clock must idle high in asynchronous mode. Mid-count configuration changes and a clear pulse fix the restart latency to the cycle.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  localparam int SEL_W  = 2;
  localparam int DIVN_W = 8;

  typedef struct packed {
    logic [SEL_W-1:0]  presc;
    logic [DIVN_W-1:0] div;
    logic              dbl;
    logic              ratio8;
    logic              sync;
  } sbg_cfg_t;
endpackage

// File: rtl/sbg_prescaler.sv
module sbg_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = 2 * ((1 << SEL_W) - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim  = CNT_W'((64'(1) << (2 * sel)) - 64'(1));
    tick = !clr && (cnt_q == lim);
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sbg_divider.sv
module sbg_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             half,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W:0] cnt_q, cnt_d, top;

  always_comb begin
    top  = half ? {1'b0, div} : {div, 1'b1};
    tick = !clr && en && (cnt_q == top);
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (en)   cnt_d = cnt_q + (DIV_W+1)'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sbg_oversample.sv
module sbg_oversample #(
  parameter int RATIO_HI = 16,
  parameter int RATIO_LO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic base_tick,
  input  logic sync,
  input  logic ratio8,
  output logic bit_tick,
  output logic sclk
);
  localparam int OVS_W = $clog2(RATIO_HI);

  logic [OVS_W-1:0] cnt_q, cnt_d, lim;
  logic             sclk_q, sclk_d;

  always_comb begin
    if (sync)        lim = OVS_W'(1);
    else if (ratio8) lim = OVS_W'(RATIO_LO - 1);
    else             lim = OVS_W'(RATIO_HI - 1);
    bit_tick = base_tick && (cnt_q == lim);

    if (clr)            cnt_d = '0;
    else if (bit_tick)  cnt_d = '0;
    else if (base_tick) cnt_d = cnt_q + OVS_W'(1);
    else                cnt_d = cnt_q;

    if (clr || !sync)   sclk_d = 1'b1;
    else if (base_tick) sclk_d = !sclk_q;
    else                sclk_d = sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;
endmodule

// File: rtl/serial_baud_gen.sv
module serial_baud_gen
  import sbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic [SEL_W-1:0]  presc_sel,
  input  logic [DIVN_W-1:0] divisor,
  input  logic              dbl_speed,
  input  logic              ratio8,
  input  logic              sync_mode,
  output logic              base_tick,
  output logic              bit_tick,
  output logic              sclk
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  sbg_cfg_t   cfg_now, cfg_q;
  logic       cfg_clr;
  logic       pre_tick;
  logic       half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  always_comb begin
    cfg_now.presc  = presc_sel;
    cfg_now.div    = divisor;
    cfg_now.dbl    = dbl_speed;
    cfg_now.ratio8 = ratio8;
    cfg_now.sync   = sync_mode;
    cfg_clr        = sync_clr || (cfg_now != cfg_q);
    half           = dbl_speed && !sync_mode;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) cfg_q <= '0;
    else          cfg_q <= cfg_now;
  end

  sbg_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n_s), .clr(cfg_clr), .sel(presc_sel), .tick(pre_tick)
  );

  sbg_divider #(.DIV_W(DIVN_W)) u_div (
    .clk(clk), .rst_n(rst_n_s), .clr(cfg_clr), .en(pre_tick), .half(half),
    .div(divisor), .tick(base_tick)
  );

  sbg_oversample #(.RATIO_HI(16), .RATIO_LO(8)) u_ovs (
    .clk(clk), .rst_n(rst_n_s), .clr(cfg_clr), .base_tick(base_tick),
    .sync(sync_mode), .ratio8(ratio8), .bit_tick(bit_tick), .sclk(sclk)
  );
endmodule

// File: rtl/sbg_checker.sv
module sbg_checker (
  input logic clk,
  input logic rst_n,
  input logic sync_clr,
  input logic sync_mode,
  input logic cfg_clr,
  input logic base_tick,
  input logic bit_tick,
  input logic sclk
);
  // R10
  bit_with_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> base_tick);

  // R10
  bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  // R8
  async_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && $past(!sync_mode)) |-> sclk);

  // R9
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |-> (!base_tick && !bit_tick));

  // R9
  clr_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> sclk);

  // R7
  sclk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> ($past(base_tick) || $past(cfg_clr)));

  // R7
  sclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && sync_mode) |=> sclk);
endmodule

bind serial_baud_gen sbg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .sync_mode(sync_mode),
  .cfg_clr(cfg_clr), .base_tick(base_tick), .bit_tick(bit_tick), .sclk(sclk)
);

// File: tb/serial_baud_gen_test.sv
module serial_baud_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_clr;
  logic [1:0] presc_sel;
  logic [7:0] divisor;
  logic       dbl_speed, ratio8, sync_mode;
  logic       base_tick, bit_tick, sclk;

  int tests  = 0;
  int failed = 0;

  always #4 clk = ~clk;

  serial_baud_gen uut (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .presc_sel(presc_sel),
    .divisor(divisor), .dbl_speed(dbl_speed), .ratio8(ratio8),
    .sync_mode(sync_mode), .base_tick(base_tick), .bit_tick(bit_tick), .sclk(sclk)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int base_per(input int n, input int nd, input bit dbl, input bit sy);
    int p;
    p = (4 ** n) * (nd + 1);
    if (!(dbl && !sy)) p = p * 2;
    return p;
  endfunction

  task automatic set_cfg(input int n, input int nd, input bit dbl, input bit r8, input bit sy);
    @(negedge clk);
    presc_sel = 2'(n); divisor = 8'(nd); dbl_speed = dbl; ratio8 = r8; sync_mode = sy;
  endtask

  // which: 0 base_tick, 1 bit_tick
  task automatic measure(input int which, output int per);
    int c;
    do @(negedge clk); while (!(which == 0 ? base_tick : bit_tick));
    c = 0;
    do begin @(negedge clk); c++; end while (!(which == 0 ? base_tick : bit_tick));
    per = c;
  endtask

  task automatic t_reset();
    check("R1", "base_tick in reset", int'(base_tick), 0);
    check("R1", "bit_tick in reset", int'(bit_tick), 0);
    check("R1", "sclk in reset", int'(sclk), 1);
  endtask

  task automatic t_async(input string req, input int n, input int nd, input bit dbl, input bit r8);
    int pb, pt, eb;
    set_cfg(n, nd, dbl, r8, 1'b0);
    eb = base_per(n, nd, dbl, 1'b0);
    measure(0, pb);
    check(req, $sformatf("base period n=%0d N=%0d dbl=%0d", n, nd, dbl), pb, eb);
    measure(1, pt);
    check(req, $sformatf("bit period n=%0d N=%0d dbl=%0d r8=%0d", n, nd, dbl, r8),
          pt, eb * (r8 ? 8 : 16));
  endtask

  task automatic t_sync(input int n, input int nd, input bit dbl);
    int pb, pt, lo, hi, eb;
    set_cfg(n, nd, dbl, 1'b0, 1'b1);
    eb = base_per(n, nd, dbl, 1'b1);
    measure(0, pb);
    check("R7", "sync base period", pb, eb);
    measure(1, pt);
    check("R7", "sync bit period", pt, 4 * (4 ** n) * (nd + 1));
    do @(negedge clk); while (sclk != 1'b0);
    lo = 0;
    while (sclk == 1'b0) begin lo++; @(negedge clk); end
    hi = 0;
    while (sclk == 1'b1) begin hi++; @(negedge clk); end
    check("R7", "sclk low time", lo, eb);
    check("R7", "sclk high time", hi, eb);
  endtask

  task automatic t_async_sclk();
    int lows;
    set_cfg(0, 1, 1'b0, 1'b1, 1'b0);
    lows = 0;
    repeat (300) begin @(negedge clk); if (!sclk) lows++; end
    check("R8", "async sclk low samples", lows, 0);
  endtask

  task automatic t_bit_pulse();
    int wide;
    set_cfg(0, 1, 1'b0, 1'b1, 1'b0);
    do @(negedge clk); while (!bit_tick);
    check("R10", "base_tick with bit_tick", int'(base_tick), 1);
    @(negedge clk);
    wide = int'(bit_tick);
    check("R10", "bit_tick width", wide, 0);
  endtask

  task automatic t_restart();
    int c;
    set_cfg(1, 3, 1'b0, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    divisor = 8'd4;
    c = 0;
    do begin @(negedge clk); c++; end while (!base_tick);
    check("R9", "latency after divisor change", c, base_per(1, 4, 1'b0, 1'b0));
    // sync mode, clear while sclk is low
    set_cfg(0, 3, 1'b0, 1'b0, 1'b1);
    do @(negedge clk); while (sclk != 1'b0);
    repeat (2) @(negedge clk);
    sync_clr = 1'b1;
    @(negedge clk);
    sync_clr = 1'b0;
    check("R9", "sclk after clear", int'(sclk), 1);
    c = 1;
    while (!base_tick) begin @(negedge clk); c++; end
    check("R9", "latency after sync_clr", c, base_per(0, 3, 1'b0, 1'b1));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync_clr = 1'b0; presc_sel = 2'd0; divisor = 8'd0;
    dbl_speed = 1'b0; ratio8 = 1'b0; sync_mode = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    t_async("R4", 0, 0, 1'b0, 1'b0);
    t_async("R2", 1, 0, 1'b0, 1'b0);
    t_async("R2", 2, 1, 1'b0, 1'b0);
    t_async("R2", 3, 2, 1'b0, 1'b0);
    t_async("R3", 0, 255, 1'b0, 1'b0);
    t_async("R5", 0, 5, 1'b0, 1'b1);
    t_async("R6", 1, 2, 1'b1, 1'b0);
    t_async("R6", 0, 3, 1'b1, 1'b1);
    t_async("R6", 0, 0, 1'b1, 1'b1);
    t_sync(0, 2, 1'b0);
    t_sync(1, 1, 1'b1);
    t_async_sclk();
    t_bit_pulse();
    t_restart();

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule